// File: doc/BRIEF.md
# H-Bridge Gate Control with Dead-Time

This block turns three control levels (enable, direction, PWM) into gate commands for the four switches of an external H-bridge. There are two high-side gates and two low-side gates, one pair per leg. Each gate command has three states: source (drive on), sink (hold off) and resistive (released). A diagnostic output has three states as well: released-high, pulled-low and tri-stated. The control levels pass through a two-flop synchroniser before they are decoded. PWM high means braking: both high-side switches are on. PWM low picks one of two diagonal current paths, and direction chooses which one.

When a decoded gate turns off, it does so at once. When a decoded gate turns on, it waits a programmable number of clock cycles first. This keeps the two switches of a leg from conducting together. Fault flags act without a register in the path, so a shutdown is never held back by the synchroniser or the delay counter. Standby (enable low) has priority over every fault. A global fault (thermal, overvoltage, undervoltage) has priority over normal decode. A per-gate short-circuit kill bit forces only its own gate off.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While the synchronised enable is low, all four gate outputs are 2'b00 (resistive) and `diag` is 2'b00 (tri-state). Any fault input has no effect on this.
- R2: With enable high, PWM high and no fault, both high-side gates are 2'b10 (source) and both low-side gates are 2'b01 (sink). The direction input has no effect, and changing it in this state changes no output.
- R3: With enable high, PWM low, direction low and no fault, the steady outputs are: high-side 1 sink, low-side 1 source, high-side 2 source, low-side 2 sink.
- R4: With enable high, PWM low, direction high and no fault, the steady outputs are: high-side 1 source, low-side 1 sink, high-side 2 sink, low-side 2 source.
- R5: While any of `flt_thermal`, `flt_over` or `flt_under` is high and enable is high, all gates are 2'b01 and `diag` is 2'b01 (low). This takes effect in the same cycle, with no clock edge needed. Releasing the flag restores the previous drive in the same way.
- R6: `flt_short` bit 0 kills high-side 1, bit 1 low-side 1, bit 2 high-side 2 and bit 3 low-side 2. A set bit forces only its gate to 2'b01 and pulls `diag` to 2'b01, at once. The other gates keep their decoded state.
- R7: With enable high and no fault present, `diag` is 2'b10 (released high).
- R8: A control change set up before rising edge 1 reaches the decoder after edge 2. Any gate that the new decode turns off shows sink from edge 2 on. Gates that stay on keep sourcing.
- R9: A gate that the new decode turns on stays at sink until edge D+4, where D is `dly_cfg`, or 1 when `dly_cfg` is 0. This also applies to the first turn-on after enable rises.
- R10: A further change that reaches the decoder while the delay is still counting reloads the delay. Pending turn-ons are then timed from that later change.
- R11: The high-side and low-side gate of the same leg are never both at source.
- R12: During and after reset, before enable has been synchronised high, all gates and `diag` read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Enable level (low = standby) |
| dir_in | input | 1 | Direction select |
| pwm_in | input | 1 | PWM level (high = brake) |
| flt_thermal | input | 1 | Thermal fault flag |
| flt_over | input | 1 | Overvoltage fault flag |
| flt_under | input | 1 | Undervoltage fault flag |
| flt_short | input | 4 | Per-gate short-circuit kill bits {LS2, HS2, LS1, HS1} |
| dly_cfg | input | DLY_W | Turn-on delay in cycles (0 acts as 1) |
| gate_hs1 | output | 2 | High-side 1 gate command |
| gate_ls1 | output | 2 | Low-side 1 gate command |
| gate_hs2 | output | 2 | High-side 2 gate command |
| gate_ls2 | output | 2 | Low-side 2 gate command |
| diag | output | 2 | Diagnostic: 00 tri-state, 01 low, 10 high |

## Verification
The bench builds the block with `DLY_W` = 4. This small width lets it sweep every delay code from 0 to 15, including the code 0 that is clamped to one cycle. For each code it runs all twelve ordered transitions between the four control combinations, and checks the exact edge where each turn-off and each turn-on appears. The transitions between the two braking combinations show that direction has no effect while PWM is high. Separate runs cover a reload in the middle of a delay, each fault flag and each kill bit against a live decode, standby with faults present, and the delayed turn-on after wake-up.

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic             dir_in,
  input  logic             pwm_in,
  input  logic             flt_thermal,
  input  logic             flt_over,
  input  logic             flt_under,
  input  logic [3:0]       flt_short,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic [1:0]       gate_hs1,
  output logic [1:0]       gate_ls1,
  output logic [1:0]       gate_hs2,
  output logic [1:0]       gate_ls2,
  output logic [1:0]       diag
);
  localparam logic [1:0] ST_REL = 2'b00;
  localparam logic [1:0] ST_SNK = 2'b01;
  localparam logic [1:0] ST_SRC = 2'b10;
  localparam int NGATE = 4;

  logic [2:0] meta_q, sync_q;
  logic en_s, dir_s, pwm_s;
  logic [NGATE-1:0] want, want_q, on_q;
  logic [DLY_W-1:0] cnt_q, load_val;
  logic chg, hold, gflt;
  logic [1:0] gate_v [NGATE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {en_in, dir_in, pwm_in};
      sync_q <= meta_q;
    end
  end

  assign {en_s, dir_s, pwm_s} = sync_q;

  // bit order: 0 HS1, 1 LS1, 2 HS2, 3 LS2
  always_comb begin
    if (!en_s)      want = 4'b0000;
    else if (pwm_s) want = 4'b0101;
    else if (dir_s) want = 4'b1001;
    else            want = 4'b0110;
  end

  assign chg      = (want != want_q);
  assign hold     = chg | (cnt_q != '0);
  assign load_val = (dly_cfg == '0) ? DLY_W'(1) : dly_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      on_q   <= '0;
      cnt_q  <= '0;
    end else begin
      want_q <= want;
      on_q   <= want & (on_q | {NGATE{~hold}});
      if (chg)                cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  assign gflt = flt_thermal | flt_over | flt_under;

  for (genvar i = 0; i < NGATE; i++) begin : g_gate
    assign gate_v[i] = !en_s                  ? ST_REL :
                       (gflt | flt_short[i])  ? ST_SNK :
                       (want[i] & on_q[i])    ? ST_SRC : ST_SNK;
  end

  assign gate_hs1 = gate_v[0];
  assign gate_ls1 = gate_v[1];
  assign gate_hs2 = gate_v[2];
  assign gate_ls2 = gate_v[3];
  assign diag = !en_s ? ST_REL : (gflt | (|flt_short)) ? ST_SNK : ST_SRC;

  logic [NGATE-1:0] src_p;
  assign src_p = {gate_ls2 == ST_SRC, gate_hs2 == ST_SRC,
                  gate_ls1 == ST_SRC, gate_hs1 == ST_SRC};

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_p[0] && src_p[1]) && !(src_p[2] && src_p[3])); // R11
  AST_FAULT_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_thermal || flt_over || flt_under) |-> (src_p == '0)); // R5
  AST_SHORT_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_short & src_p) == '0); // R6
  AST_NO_EARLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> ((on_q & ~$past(on_q)) == '0)); // R9
  AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_s) |=> (on_q == '0)); // R1
endmodule

// File: tb/hbridge_gate_ctrl_test.sv
module hbridge_gate_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, dir, pwm, ft, fo, fu;
  logic [3:0] fs;
  logic [3:0] cfg;
  logic [1:0] g0, g1, g2, g3, dg;
  int total = 0;
  int bad = 0;

  hbridge_gate_ctrl #(.DLY_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .en_in(en), .dir_in(dir), .pwm_in(pwm),
    .flt_thermal(ft), .flt_over(fo), .flt_under(fu), .flt_short(fs),
    .dly_cfg(cfg), .gate_hs1(g0), .gate_ls1(g1), .gate_hs2(g2),
    .gate_ls2(g3), .diag(dg));

  function automatic logic [3:0] dec(input logic e, input logic d, input logic p);
    if (!e)     return 4'b0000;
    else if (p) return 4'b0101;
    else if (d) return 4'b1001;
    else        return 4'b0110;
  endfunction

  function automatic logic [7:0] pack(input logic [3:0] on, input logic [3:0] kill);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = (kill[i] || !on[i]) ? 2'b01 : 2'b10;
    return r;
  endfunction

  function automatic logic [7:0] gates();
    return {g3, g2, g1, g0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_state(input int s);
    dir = s[0];
    pwm = s[1];
  endtask

  task automatic leg_chk();
    chk("R11", {6'b0, (g0 == 2'b10 && g1 == 2'b10) || (g2 == 2'b10 && g3 == 2'b10)}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; dir = 1'b0; pwm = 1'b0;
    ft = 1'b0; fo = 1'b0; fu = 1'b0; fs = 4'h0; cfg = 4'h0;
    repeat (3) step();
    chk("R12", gates(), 8'h00);
    chk("R12", {6'b0, dg}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R12", gates(), 8'h00);
    en = 1'b1;

    // exhaustive sweep: every delay code, every ordered transition
    for (int c = 0; c < 16; c++) begin
      int d;
      cfg = 4'(c);
      d = (c == 0) ? 1 : c;
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          if (a != b) begin
            logic [3:0] wa, wb, we;
            set_state(a);
            repeat (25) step();
            wa = dec(1'b1, dir, pwm);
            chk(a == 0 ? "R3" : (a == 1 ? "R4" : "R2"), gates(), pack(wa, 4'h0));
            chk("R7", {6'b0, dg}, 8'h02);
            set_state(b);
            wb = dec(1'b1, dir, pwm);
            for (int k = 1; k <= d + 6; k++) begin
              step();
              we = (k < 2) ? wa : ((k < d + 4) ? (wa & wb) : wb);
              chk((k < d + 4) ? "R8" : "R9", gates(), pack(we, 4'h0));
              leg_chk();
            end
          end
        end
      end
    end

    // reload of the delay by a second change
    cfg = 4'd5;
    set_state(0);
    repeat (25) step();
    set_state(2);
    repeat (3) step();
    set_state(1);
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R10", gates(), pack((k < 2) ? 4'b0100 : ((k < 9) ? 4'b0000 : 4'b1001), 4'h0));
    end

    // global faults act without a clock edge
    cfg = 4'd2;
    set_state(0);
    repeat (25) step();
    for (int f = 0; f < 3; f++) begin
      ft = (f == 0); fo = (f == 1); fu = (f == 2);
      #1;
      chk("R5", gates(), pack(4'b0110, 4'hF));
      chk("R5", {6'b0, dg}, 8'h01);
      ft = 1'b0; fo = 1'b0; fu = 1'b0;
      #1;
      chk("R5", gates(), pack(4'b0110, 4'h0));
      chk("R7", {6'b0, dg}, 8'h02);
      step();
    end

    // per-gate kill bits
    for (int s = 0; s < 4; s += 2) begin
      set_state(s);
      repeat (25) step();
      for (int i = 0; i < 4; i++) begin
        fs = 4'(1 << i);
        #1;
        chk("R6", gates(), pack(dec(1'b1, dir, pwm), 4'(1 << i)));
        chk("R6", {6'b0, dg}, 8'h01);
        fs = 4'h0;
        #1;
        chk("R6", gates(), pack(dec(1'b1, dir, pwm), 4'h0));
        step();
      end
    end

    // standby, faults ignored
    en = 1'b0;
    repeat (3) step();
    chk("R1", gates(), 8'h00);
    chk("R1", {6'b0, dg}, 8'h00);
    ft = 1'b1; fs = 4'hF;
    #1;
    chk("R1", gates(), 8'h00);
    chk("R1", {6'b0, dg}, 8'h00);
    ft = 1'b0; fs = 4'h0;

    // wake-up turn-on is delayed too
    cfg = 4'd3;
    set_state(0);
    step();
    en = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      step();
      if (k < 2) chk("R9", gates(), 8'h00);
      else       chk("R9", gates(), pack((k < 7) ? 4'b0000 : 4'b0110, 4'h0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule